// File: doc/BRIEF.md
# Host Mailbox Register Block

This block sits on the card side of a small eight-address I/O window that a host processor uses to talk to an embedded core. Through the window the host reaches a data port, a status byte, a control byte, an interrupt-acknowledge port and an interrupt-select byte. The status byte holds two separate handshake state fields. The host owns the transmit field and the core owns the receive field. A status read merges the two fields into one byte.

The host signals the core by ringing doorbells. It writes a control bit low and then high, and only the rising edge produces a one-cycle event toward the core. The same control byte holds the core in reset and selects 16-bit data transfers. The core raises interrupt requests. These requests stay pending until the host reads the acknowledge offset. The interrupt output is gated by an enable bit in the interrupt-select byte.

Host accesses are synchronous single-cycle strobes. Read data appears on `host_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `hmb_host_regs`

## Requirements
- R1: After a synchronous reset, every stored register reads zero, and `host_rdata`, `h2c_valid`, `core_reset`, `rx_bell`, `tx_bell`, `rx_ready` and `irq_out` are all low.
- R2: A write to offset 0 loads the host-to-core slot and raises `h2c_valid`, which holds along with stable data until a cycle with `h2c_ready` high. A write while `h2c_valid` is high is dropped. The slot carries 16 bits with `h2c_wide`=1 only when `host_wide` is high and control bit 5 is set. Otherwise it carries the low byte, zero-extended.
- R3: A read of offset 0 while `c2h_valid` is high returns `c2h_data` and pulses `c2h_ready` for that cycle. The value is the full word for a wide access in 16-bit mode and the low byte otherwise. A read while `c2h_valid` is low returns 0 and pops nothing.
- R4: Offset 2 writes update only status bits [3:0]: the transmit state in [2:0] (0 idle, 1 high-length ready, 2 high-length taken, 3 done, 4 moving, 5 error, 6 low-length ready, 7 low-length taken) and clear-NAK in bit 3. These drive `host_tx_state` and `host_clrnak`. A status read returns {`core_wakeup`, `core_rx_state`, bits [3:0]}.
- R5: `rx_ready` is high in the cycle after `core_rx_state` equals 1, 5 or 6, and low for any other code.
- R6: Offset 4 stores bits [5:0] of the written value and reads back with bits above 5 as zero. Control bit 4 drives `core_reset`.
- R7: A 0-to-1 change of control bit 0 (or bit 1) gives a one-cycle pulse on `rx_bell` (or `tx_bell`) in the second cycle after the write. Rewriting a bit that is already 1 gives no pulse.
- R8: A `core_irq_req` cycle sets a pending flag. `irq_out` equals pending AND the enable bit, one cycle later.
- R9: Any read of offset 5 clears the pending flag and returns 0. A request in the same cycle wins, so the flag stays set.
- R10: Offset 6 stores the line number in bits [2:0], which drives `irq_line`, and the enable in bit 4. Other bits read zero.
- R11: Offsets 1, 3 and 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Offset within the window |
| host_wide | input | 1 | 16-bit access request |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| h2c_data | output | 16 | Host-to-core data slot |
| h2c_wide | output | 1 | Slot holds a 16-bit word |
| h2c_valid | output | 1 | Slot occupied |
| h2c_ready | input | 1 | Core takes the slot |
| c2h_data | input | 16 | Core-to-host data |
| c2h_valid | input | 1 | Core data available |
| c2h_ready | output | 1 | Host consumed core data |
| core_rx_state | input | 3 | Core-owned receive handshake state |
| core_wakeup | input | 1 | Core wakeup flag |
| host_tx_state | output | 3 | Host-owned transmit handshake state |
| host_clrnak | output | 1 | Host clear-NAK flag |
| rx_ready | output | 1 | Receive side has something for the host |
| core_reset | output | 1 | Holds the core in reset |
| rx_bell | output | 1 | Receive doorbell pulse |
| tx_bell | output | 1 | Transmit doorbell pulse |
| core_irq_req | input | 1 | Core interrupt event |
| irq_out | output | 1 | Interrupt request to host |
| irq_line | output | 3 | Selected interrupt line number |

## Verification
Some properties are checked by assertions on every cycle. Each doorbell pulse lasts one cycle. The host-to-core slot holds its data while the core has not taken it. A request always leaves the interrupt pending, and an acknowledge with no request in the same cycle clears it. The interrupt output never rises without the enable bit, and a control write drives the reset output. Other behaviour is shown only by the directed scenarios. These cover the merged status view and the ownership of each field, the receive-ready decode over all eight codes, byte versus word packing in each mode, dropped writes, empty reads, the masking of unused bits and offsets, and the request-wins collision at acknowledge.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam logic [2:0] OFF_CTRL = 3'd4;
  localparam logic [2:0] OFF_EOI  = 3'd5;
  localparam logic [2:0] OFF_ISEL = 3'd6;

  localparam int CTRL_W    = 6;
  localparam int CB_RXBELL = 0;
  localparam int CB_TXBELL = 1;
  localparam int CB_RESET  = 4;
  localparam int CB_WIDE   = 5;
  localparam int NBELL     = 2;
  localparam int ISEL_EN   = 4;

  typedef enum logic [2:0] {
    HS_IDLE     = 3'd0,
    HS_HI_AVAIL = 3'd1,
    HS_HI_ACK   = 3'd2,
    HS_DONE     = 3'd3,
    HS_MOVING   = 3'd4,
    HS_FAULT    = 3'd5,
    HS_LO_AVAIL = 3'd6,
    HS_LO_ACK   = 3'd7
  } hs_state_e;
endpackage

// File: rtl/hmb_doorbell.sv
module hmb_doorbell #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bell
    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i]  <= 1'b0;
        pulse[i] <= 1'b0;
      end else begin
        prev[i]  <= lvl[i];
        pulse[i] <= lvl[i] & ~prev[i];
      end
    end

    AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      pulse[i] |=> !pulse[i]); // R7
  end
endmodule

// File: rtl/hmb_irq.sv
module hmb_irq (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  input  logic en,
  output logic irq
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (req)      pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      irq <= pend & en;
    end
  end

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
    req |=> pend); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> !pend); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en)); // R8
endmodule

// File: rtl/hmb_dataport.sv
module hmb_dataport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_data,
  output logic          out_wide,
  output logic          out_valid,
  input  logic          out_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] rd_val
);
  localparam int BW = DW / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wide  <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (wr_stb && !out_valid) begin
        out_valid <= 1'b1;
        out_wide  <= wide;
        out_data  <= wide ? wdata : {{(DW-BW){1'b0}}, wdata[BW-1:0]};
      end
    end
  end

  always_comb begin
    in_ready = rd_stb & in_valid;
    if (!in_valid)  rd_val = '0;
    else if (wide)  rd_val = in_data;
    else            rd_val = {{(DW-BW){1'b0}}, in_data[BW-1:0]};
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R2
endmodule

// File: rtl/hmb_host_regs.sv
module hmb_host_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wide,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] h2c_data,
  output logic              h2c_wide,
  output logic              h2c_valid,
  input  logic              h2c_ready,
  input  logic [DATA_W-1:0] c2h_data,
  input  logic              c2h_valid,
  output logic              c2h_ready,
  input  logic [2:0]        core_rx_state,
  input  logic              core_wakeup,
  output logic [2:0]        host_tx_state,
  output logic              host_clrnak,
  output logic              rx_ready,
  output logic              core_reset,
  output logic              rx_bell,
  output logic              tx_bell,
  input  logic              core_irq_req,
  output logic              irq_out,
  output logic [2:0]        irq_line
);
  import hmb_pkg::*;

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFF_EOI);
  localparam logic [ADDR_W-1:0] A_ISEL = ADDR_W'(OFF_ISEL);

  logic [3:0]        stat_lo;
  logic [CTRL_W-1:0] ctl;
  logic [2:0]        isel_line;
  logic              isel_en;
  logic              wide_acc;
  logic [DATA_W-1:0] dp_rd;
  logic [DATA_W-1:0] rd_mux;
  logic [NBELL-1:0]  bell_lvl;
  logic [NBELL-1:0]  bell_pulse;
  hs_state_e         rx_hs;

  assign wide_acc = host_wide & ctl[CB_WIDE];
  assign rx_hs    = hs_state_e'(core_rx_state);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_lo   <= '0;
      ctl       <= '0;
      isel_line <= '0;
      isel_en   <= 1'b0;
    end else if (host_wr) begin
      case (host_addr)
        A_STAT: stat_lo <= host_wdata[3:0];
        A_CTRL: ctl     <= host_wdata[CTRL_W-1:0];
        A_ISEL: begin
          isel_line <= host_wdata[2:0];
          isel_en   <= host_wdata[ISEL_EN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (host_addr)
      A_DATA:  rd_mux = dp_rd;
      A_STAT:  rd_mux = DATA_W'({core_wakeup, core_rx_state, stat_lo});
      A_CTRL:  rd_mux = DATA_W'(ctl);
      A_ISEL:  rd_mux = DATA_W'({isel_en, 1'b0, isel_line});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      rx_ready   <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= rd_mux;
      rx_ready <= (rx_hs == HS_LO_AVAIL) || (rx_hs == HS_HI_AVAIL) ||
                  (rx_hs == HS_FAULT);
    end
  end

  assign host_tx_state = stat_lo[2:0];
  assign host_clrnak   = stat_lo[3];
  assign core_reset    = ctl[CB_RESET];
  assign irq_line      = isel_line;

  hmb_dataport #(.DW(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (host_wr && host_addr == A_DATA),
    .rd_stb    (host_rd && host_addr == A_DATA),
    .wide      (wide_acc),
    .wdata     (host_wdata),
    .out_data  (h2c_data),
    .out_wide  (h2c_wide),
    .out_valid (h2c_valid),
    .out_ready (h2c_ready),
    .in_data   (c2h_data),
    .in_valid  (c2h_valid),
    .in_ready  (c2h_ready),
    .rd_val    (dp_rd)
  );

  assign bell_lvl = {ctl[CB_TXBELL], ctl[CB_RXBELL]};

  hmb_doorbell #(.N(NBELL)) u_bell (
    .clk   (clk),
    .rst   (rst),
    .lvl   (bell_lvl),
    .pulse (bell_pulse)
  );

  assign rx_bell = bell_pulse[0];
  assign tx_bell = bell_pulse[1];

  hmb_irq u_irq (
    .clk (clk),
    .rst (rst),
    .req (core_irq_req),
    .ack (host_rd && host_addr == A_EOI),
    .en  (isel_en),
    .irq (irq_out)
  );

  AST_CTRL_RESET: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_CTRL) |=> (core_reset == $past(host_wdata[CB_RESET]))); // R6
endmodule

// File: tb/hmb_host_regs_test.sv
module hmb_host_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_wide = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [15:0] h2c_data;
  logic        h2c_wide, h2c_valid;
  logic        h2c_ready = 1'b0;
  logic [15:0] c2h_data = '0;
  logic        c2h_valid = 1'b0;
  logic        c2h_ready;
  logic [2:0]  core_rx_state = '0;
  logic        core_wakeup = 1'b0;
  logic [2:0]  host_tx_state;
  logic        host_clrnak, rx_ready, core_reset, rx_bell, tx_bell;
  logic        core_irq_req = 1'b0;
  logic        irq_out;
  logic [2:0]  irq_line;

  int checks = 0, fails = 0, pops = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hmb_host_regs uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wide(host_wide),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .h2c_data(h2c_data), .h2c_wide(h2c_wide),
    .h2c_valid(h2c_valid), .h2c_ready(h2c_ready), .c2h_data(c2h_data),
    .c2h_valid(c2h_valid), .c2h_ready(c2h_ready), .core_rx_state(core_rx_state),
    .core_wakeup(core_wakeup), .host_tx_state(host_tx_state),
    .host_clrnak(host_clrnak), .rx_ready(rx_ready), .core_reset(core_reset),
    .rx_bell(rx_bell), .tx_bell(tx_bell), .core_irq_req(core_irq_req),
    .irq_out(irq_out), .irq_line(irq_line)
  );

  always @(posedge clk) if (c2h_ready && c2h_valid) pops <= pops + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, logic w);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wide = w; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic w, output logic [15:0] v);
    @(negedge clk);
    host_addr = a; host_wide = w; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 rdata", host_rdata, 0);
    check("R1 outputs", {h2c_valid, core_reset, rx_bell, tx_bell, rx_ready, irq_out}, 0);
    rd(3'd4, 1'b0, v); check("R1 ctrl", v, 0);
    rd(3'd6, 1'b0, v); check("R1 isel", v, 0);
    rd(3'd2, 1'b0, v); check("R1 status", v, 0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(3'd2, 16'h00FD, 1'b0);
    check("R4 tx_state", host_tx_state, 5);
    check("R4 clrnak", host_clrnak, 1);
    core_rx_state = 3'd6; core_wakeup = 1'b1;
    rd(3'd2, 1'b0, v); check("R4 merged", v, 16'h00ED);
    core_rx_state = 3'd0; core_wakeup = 1'b0;
    rd(3'd2, 1'b0, v); check("R4 core bits live", v, 16'h000D);
  endtask

  task automatic t_rxready();
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); core_rx_state = 3'(s);
      @(negedge clk);
      check("R5 rx_ready", rx_ready, (s == 1 || s == 5 || s == 6) ? 1 : 0);
    end
    core_rx_state = 3'd0;
  endtask

  task automatic t_control();
    logic [15:0] v;
    wr(3'd4, 16'hFFFF, 1'b0);
    rd(3'd4, 1'b0, v); check("R6 mask", v, 16'h003F);
    check("R6 reset hi", core_reset, 1);
    wr(3'd4, 16'h0000, 1'b0);
    check("R6 reset lo", core_reset, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_bell();
    wr(3'd4, 16'h0001, 1'b0);
    @(negedge clk); check("R7 rx bell", {rx_bell, tx_bell}, 2'b10);
    @(negedge clk); check("R7 rx bell one cycle", {rx_bell, tx_bell}, 2'b00);
    wr(3'd4, 16'h0001, 1'b0);
    @(negedge clk); check("R7 no re-ring", {rx_bell, tx_bell}, 2'b00);
    @(negedge clk); check("R7 no re-ring", {rx_bell, tx_bell}, 2'b00);
    wr(3'd4, 16'h0000, 1'b0);
    wr(3'd4, 16'h0003, 1'b0);
    @(negedge clk); check("R7 tx bell", {rx_bell, tx_bell}, 2'b11);
    @(negedge clk); check("R7 both end", {rx_bell, tx_bell}, 2'b00);
    wr(3'd4, 16'h0000, 1'b0);
  endtask

  task automatic drain();
    @(negedge clk); h2c_ready = 1'b1;
    @(negedge clk); h2c_ready = 1'b0;
  endtask

  task automatic t_dwrite();
    wr(3'd0, 16'hABCD, 1'b1);
    check("R2 byte mode", {h2c_valid, h2c_wide, h2c_data}, {2'b10, 16'h00CD});
    wr(3'd0, 16'h1111, 1'b0);
    check("R2 drop when full", h2c_data, 16'h00CD);
    drain(); check("R2 drained", h2c_valid, 0);
    wr(3'd4, 16'h0020, 1'b0);
    wr(3'd0, 16'hABCD, 1'b1);
    check("R2 word", {h2c_valid, h2c_wide, h2c_data}, {2'b11, 16'hABCD});
    drain();
    wr(3'd0, 16'h1234, 1'b0);
    check("R2 byte in wide mode", {h2c_valid, h2c_wide, h2c_data}, {2'b10, 16'h0034});
    drain();
  endtask

  task automatic t_dread();
    logic [15:0] v;
    int p0;
    p0 = pops;
    rd(3'd0, 1'b1, v); check("R3 empty read", v, 0);
    check("R3 no pop", pops, p0);
    c2h_data = 16'hBEEF; c2h_valid = 1'b1;
    rd(3'd0, 1'b1, v); check("R3 word read", v, 16'hBEEF);
    check("R3 one pop", pops, p0 + 1);
    rd(3'd0, 1'b0, v); check("R3 byte read", v, 16'h00EF);
    c2h_valid = 1'b0;
    wr(3'd4, 16'h0000, 1'b0);
    c2h_valid = 1'b1;
    rd(3'd0, 1'b1, v); check("R3 wide off", v, 16'h00EF);
    c2h_valid = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); core_irq_req = 1'b1;
    @(negedge clk); core_irq_req = 1'b0;
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(3'd6, 16'h00FF, 1'b0);
    rd(3'd6, 1'b0, v); check("R10 isel mask", v, 16'h0017);
    check("R10 line", irq_line, 7);
    pulse_req();
    @(negedge clk); check("R8 irq raised", irq_out, 1);
    rd(3'd5, 1'b0, v); check("R9 eoi data", v, 0);
    @(negedge clk); check("R9 irq cleared", irq_out, 0);
    wr(3'd6, 16'h0003, 1'b0);
    check("R10 line 3", irq_line, 3);
    pulse_req();
    @(negedge clk); @(negedge clk); check("R8 gated", irq_out, 0);
    wr(3'd6, 16'h0013, 1'b0);
    @(negedge clk); check("R8 pending kept", irq_out, 1);
    @(negedge clk);
    host_addr = 3'd5; host_rd = 1'b1; core_irq_req = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; core_irq_req = 1'b0;
    @(negedge clk); @(negedge clk); check("R9 request wins", irq_out, 1);
    rd(3'd5, 1'b0, v);
    @(negedge clk); check("R9 cleared", irq_out, 0);
  endtask

  task automatic t_unused();
    logic [15:0] v;
    wr(3'd4, 16'h000C, 1'b0);
    wr(3'd1, 16'hFFFF, 1'b0);
    wr(3'd3, 16'hFFFF, 1'b0);
    wr(3'd7, 16'hFFFF, 1'b0);
    rd(3'd1, 1'b0, v); check("R11 off1", v, 0);
    rd(3'd3, 1'b0, v); check("R11 off3", v, 0);
    rd(3'd7, 1'b0, v); check("R11 off7", v, 0);
    rd(3'd4, 1'b0, v); check("R11 ctrl untouched", v, 16'h000C);
    rd(3'd6, 1'b0, v); check("R11 isel untouched", v, 16'h0013);
    rd(3'd2, 1'b0, v); check("R11 status untouched", v, 16'h000D);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_rxready();
    t_control();
    t_bell();
    t_dwrite();
    t_dread();
    t_irq();
    t_unused();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule